// File: doc/BRIEF.md
# Sticky-Request Interrupt Controller

This block gathers three interrupt sources for a small processor core: a rising edge on an asynchronous external pin, a one-cycle pulse when a timer wraps back to zero, and a one-cycle pulse when a serial receiver finishes a byte. Each source sets its own request flag, and the flag stays set until software clears it. A per-source enable mask decides which sources may set a flag. A single global enable decides whether pending flags may interrupt the core.

At every instruction boundary that the core signals, the block checks for an enabled pending request. If one exists and the global enable is set, it raises a one-cycle take signal and presents the handler address. It also stores the resume address in a read-only register, records which source is being served, and drops the global enable. Three decoded custom operations change the global enable: set, clear and return. Return toggles the enable and hands the saved address back to the core. Software reaches the vector, the active-source number, the enable mask and the saved address through a small register window addressed by the low byte of the peripheral address.

Top module: `irqlatch_top`

## Requirements
- R1: After reset, `pending` is 0, `take_irq` is 0, and reads at offsets 0x20, 0x24, 0x28 and 0x48 return 0. The global enable is 0.
- R2: Bit i of the mask at offset 0x28 enables source i. While that bit is 1, source i sets `pending[i]`, and the flag stays set with no further source activity. The sources are: 0 = rising edge of `ext_pin`, 1 = `tmr_wrap`, 2 = `rx_done`. While the bit is 0, source activity leaves `pending[i]` at 0.
- R3: Writing exactly 0 at offset 0x1C clears `pending[0]`. Writing exactly 0 at offset 0x44 clears `pending[1]`. Any read at offset 0x0C clears `pending[2]`. A nonzero write at 0x1C or 0x44 leaves the flags unchanged.
- R4: Writing a 0 into bit i of the mask at 0x28 clears `pending[i]` by the next cycle.
- R5: The global enable is set by `op_sei` and cleared by `op_cli`. It is also cleared in the cycle after an interrupt is taken.
- R6: `take_irq` is high exactly in a cycle where `insn_done` is high, the global enable is set and `pending` is nonzero. In the following cycle, the read at 0x48 and `ret_pc` both hold the `cur_pc` value from the take cycle.
- R7: `op_iret` inverts the global enable and makes the read at 0x24 return 0 from the next cycle on. `ret_pc` always shows the saved address.
- R8: The read at 0x24 returns the served source number plus one after a take.
- R9: When several flags are pending, the lowest-numbered source is served first.
- R10: The vector written at offset 0x20 reads back, and appears on `vec_pc`, with bits 1:0 forced to 0.
- R11: An `ext_pin` that stays high produces only one request. After that request is cleared, no new request appears until the pin goes low and rises again.
- R12: If an enabled flag is still pending after a return, the next `insn_done` takes another interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external request pin |
| tmr_wrap | input | 1 | Timer wrapped to zero (one-cycle pulse) |
| rx_done | input | 1 | Serial byte received (one-cycle pulse) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset within the peripheral page |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational, 0 when not reading) |
| insn_done | input | 1 | Core is at an instruction boundary |
| cur_pc | input | 32 | Address at which to resume after the handler |
| op_sei | input | 1 | Decoded set-global-enable operation |
| op_cli | input | 1 | Decoded clear-global-enable operation |
| op_iret | input | 1 | Decoded return-from-interrupt operation |
| take_irq | output | 1 | Branch to the handler now |
| vec_pc | output | 32 | Handler address |
| ret_pc | output | 32 | Saved resume address |
| pending | output | 3 | Request flags |

## Verification
The properties assume that the three decoded operations never pulse in the same cycle, and that `tmr_wrap`, `rx_done` and the register strobes are single-cycle pulses. They also assume that `ext_pin` holds each level for at least three clocks, so the synchronizer sees every edge. The stimulus drives one operation or one register access per cycle and holds the pin for four clocks after each change. It sweeps every nonzero combination of pending sources through the full take, clear and return loop, and it keeps operation strobes out of the cycles that carry `insn_done`.

// File: rtl/irqlatch_pkg.sv
package irqlatch_pkg;
    localparam int XLEN  = 32;
    localparam int OFF_W = 8;
    localparam int NSRC  = 3;
    localparam int NUM_W = $clog2(NSRC + 1);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    localparam logic [OFF_W-1:0] OFF_RXDATA = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_EXTCLR = 8'h1C;
    localparam logic [OFF_W-1:0] OFF_IVEC   = 8'h20;
    localparam logic [OFF_W-1:0] OFF_INUM   = 8'h24;
    localparam logic [OFF_W-1:0] OFF_IEN    = 8'h28;
    localparam logic [OFF_W-1:0] OFF_TMRCLR = 8'h44;
    localparam logic [OFF_W-1:0] OFF_PREV   = 8'h48;

    typedef struct packed {
        logic              gie;
        logic [NSRC-1:0]   ien;
        logic [NUM_W-1:0]  inum;
        logic [XLEN-1:2]   ivec;
        logic [XLEN-1:0]   prev;
    } ctl_t;
endpackage

// File: rtl/irqlatch_sync.sv
module irqlatch_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], pin};
        s_d.last  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = s_q.chain[STAGES-1] & ~s_q.last;
endmodule

// File: rtl/irqlatch_bank.sv
module irqlatch_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ien_cur,
    input  logic [N-1:0] ien_nxt,
    output logic [N-1:0] flags
);
    logic [N-1:0] pend_d, pend_q;

    // A clear in the same cycle as a new event wins; software clears
    // after it has observed the event.
    for (genvar i = 0; i < N; i++) begin : g_src
        always_comb begin
            pend_d[i] = ien_nxt[i] & ~clr[i] & (pend_q[i] | (src[i] & ien_cur[i]));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign flags = pend_q;
endmodule

// File: rtl/irqlatch_pick.sv
module irqlatch_pick #(
    parameter int N = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqlatch_top.sv
module irqlatch_top
    import irqlatch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             tmr_wrap,
    input  logic             rx_done,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [OFF_W-1:0] reg_addr,
    input  logic [XLEN-1:0]  reg_wdata,
    output logic [XLEN-1:0]  reg_rdata,
    input  logic             insn_done,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic             op_sei,
    input  logic             op_cli,
    input  logic             op_iret,
    output logic             take_irq,
    output logic [XLEN-1:0]  vec_pc,
    output logic [XLEN-1:0]  ret_pc,
    output logic [NSRC-1:0]  pending
);
    ctl_t st_d, st_q;

    logic             ext_rise;
    logic [NSRC-1:0]  src_ev;
    logic [NSRC-1:0]  clr_ev;
    logic [NSRC-1:0]  flags;
    logic             any_req;
    logic [IDX_W-1:0] sel_idx;
    logic             take;
    logic             gie_now;
    logic [NSRC-1:0]  ien_now;

    irqlatch_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin),
        .rise (ext_rise)
    );

    assign src_ev = {rx_done, tmr_wrap, ext_rise};

    always_comb begin
        clr_ev    = '0;
        clr_ev[0] = reg_wr && (reg_addr == OFF_EXTCLR) && (reg_wdata == '0);
        clr_ev[1] = reg_wr && (reg_addr == OFF_TMRCLR) && (reg_wdata == '0);
        clr_ev[2] = reg_rd && (reg_addr == OFF_RXDATA);
    end

    irqlatch_bank #(.N(NSRC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (src_ev),
        .clr    (clr_ev),
        .ien_cur(st_q.ien),
        .ien_nxt(st_d.ien),
        .flags  (flags)
    );

    irqlatch_pick #(.N(NSRC)) u_pick (
        .req  (flags),
        .valid(any_req),
        .idx  (sel_idx)
    );

    assign take = insn_done && st_q.gie && any_req;

    always_comb begin
        st_d = st_q;
        if (reg_wr && (reg_addr == OFF_IEN))
            st_d.ien = reg_wdata[NSRC-1:0];
        if (reg_wr && (reg_addr == OFF_IVEC))
            st_d.ivec = reg_wdata[XLEN-1:2];
        // Priority: taking an interrupt, then return, then clear, then set.
        if (take) begin
            st_d.gie  = 1'b0;
            st_d.inum = NUM_W'(sel_idx) + NUM_W'(1);
            st_d.prev = cur_pc;
        end else if (op_iret) begin
            st_d.gie  = ~st_q.gie;
            st_d.inum = '0;
        end else if (op_cli) begin
            st_d.gie  = 1'b0;
        end else if (op_sei) begin
            st_d.gie  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                OFF_IVEC: reg_rdata = {st_q.ivec, 2'b00};
                OFF_INUM: reg_rdata = XLEN'(st_q.inum);
                OFF_IEN:  reg_rdata = XLEN'(st_q.ien);
                OFF_PREV: reg_rdata = st_q.prev;
                default:  reg_rdata = '0;
            endcase
        end
    end

    assign take_irq = take;
    assign vec_pc   = {st_q.ivec, 2'b00};
    assign ret_pc   = st_q.prev;
    assign pending  = flags;
    assign gie_now  = st_q.gie;
    assign ien_now  = st_q.ien;
endmodule

// File: rtl/irqlatch_chk.sv
module irqlatch_chk
    import irqlatch_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [OFF_W-1:0] reg_addr,
    input logic [XLEN-1:0]  reg_wdata,
    input logic             insn_done,
    input logic [XLEN-1:0]  cur_pc,
    input logic             op_sei,
    input logic             op_cli,
    input logic             op_iret,
    input logic             take_irq,
    input logic [XLEN-1:0]  vec_pc,
    input logic [XLEN-1:0]  ret_pc,
    input logic [NSRC-1:0]  pending,
    input logic             gie,
    input logic [NSRC-1:0]  ien
);
    p_vec_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pc[1:0] == 2'b00);

    p_take_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (insn_done && gie && (pending != '0)));

    p_take_drops_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !gie);

    p_prev_saved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> (ret_pc == $past(cur_pc)));

    p_ien_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_IEN) |=> ((pending & ~$past(reg_wdata[NSRC-1:0])) == '0));

    p_ext_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_EXTCLR && reg_wdata == '0) |=> !pending[0]);

    p_tmr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_TMRCLR && reg_wdata == '0) |=> !pending[1]);

    p_rx_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_RXDATA) |=> !pending[2]);

    p_iret_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_iret && !take_irq) |=> (gie != $past(gie)));

    p_sei_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sei && !op_cli && !op_iret && !take_irq) |=> gie);

    p_cli_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cli && !op_iret) |=> !gie);

    p_masked_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & ~ien) == '0);
endmodule

bind irqlatch_top irqlatch_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .insn_done(insn_done),
    .cur_pc   (cur_pc),
    .op_sei   (op_sei),
    .op_cli   (op_cli),
    .op_iret  (op_iret),
    .take_irq (take_irq),
    .vec_pc   (vec_pc),
    .ret_pc   (ret_pc),
    .pending  (pending),
    .gie      (gie_now),
    .ien      (ien_now)
);

// File: tb/irqlatch_top_tb.sv
module irqlatch_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pin = 1'b0, tmr_wrap = 1'b0, rx_done = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        insn_done = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        op_sei = 1'b0, op_cli = 1'b0, op_iret = 1'b0;
    logic        take_irq;
    logic [31:0] vec_pc, ret_pc;
    logic [2:0]  pending;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    irqlatch_top u_dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_wrap(tmr_wrap),
        .rx_done(rx_done), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .insn_done(insn_done),
        .cur_pc(cur_pc), .op_sei(op_sei), .op_cli(op_cli), .op_iret(op_iret),
        .take_irq(take_irq), .vec_pc(vec_pc), .ret_pc(ret_pc), .pending(pending)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #5 d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic pin_rise();
        ext_pin = 1'b1; repeat (4) tick();
        ext_pin = 1'b0; repeat (4) tick();
    endtask

    task automatic pulse_src(input int s);
        if (s == 0) pin_rise();
        else if (s == 1) begin tmr_wrap = 1'b1; tick(); tmr_wrap = 1'b0; end
        else begin rx_done = 1'b1; tick(); rx_done = 1'b0; end
    endtask

    task automatic clear_src(input int s);
        if (s == 0) wr(8'h1C, 32'h0);
        else if (s == 1) wr(8'h44, 32'h0);
        else rd(8'h0C, rv);
    endtask

    task automatic op(input int k);
        if (k == 0) op_sei = 1'b1; else if (k == 1) op_cli = 1'b1; else op_iret = 1'b1;
        tick();
        op_sei = 1'b0; op_cli = 1'b0; op_iret = 1'b0;
    endtask

    // Boundary strobe; returns the take flag seen in that cycle.
    task automatic boundary(input logic [31:0] pc, output logic tk);
        insn_done = 1'b1; cur_pc = pc;
        #5 tk = take_irq;
        tick();
        insn_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic tk;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 pending", 32'(pending), 32'h0);
        chk("R1 take", 32'(take_irq), 32'h0);
        rd(8'h20, rv); chk("R1 ivec", rv, 32'h0);
        rd(8'h24, rv); chk("R1 inum", rv, 32'h0);
        rd(8'h28, rv); chk("R1 ien", rv, 32'h0);
        rd(8'h48, rv); chk("R1 prev", rv, 32'h0);

        // R10 vector alignment sweep
        for (int k = 0; k < 8; k++) begin
            logic [31:0] v;
            v = 32'h1357_9BDF * (k + 1) + 32'(k);
            wr(8'h20, v);
            rd(8'h20, rv); chk("R10 ivec read", rv, v & 32'hFFFF_FFFC);
            chk("R10 vec_pc", vec_pc, v & 32'hFFFF_FFFC);
        end
        wr(8'h20, 32'h0000_4003);

        // R2 disabled sources stay clear
        for (int s = 0; s < 3; s++) pulse_src(s);
        chk("R2 masked", 32'(pending), 32'h0);

        // R2 set per source with only its enable bit
        for (int s = 0; s < 3; s++) begin
            wr(8'h28, 32'(1 << s));
            for (int t = 0; t < 3; t++) pulse_src(t);
            chk("R2 single enable", 32'(pending), 32'(1 << s));
            repeat (5) tick();
            chk("R2 sticky", 32'(pending), 32'(1 << s));
            wr(8'h28, 32'h0);
            chk("R4 ien clear", 32'(pending), 32'h0);
        end

        wr(8'h28, 32'h7);
        rd(8'h28, rv); chk("R2 ien read", rv, 32'h7);

        // R3 nonzero writes ignored, zero writes clear
        for (int s = 0; s < 3; s++) pulse_src(s);
        chk("R2 all set", 32'(pending), 32'h7);
        wr(8'h1C, 32'h1); wr(8'h44, 32'h80);
        chk("R3 nonzero ignored", 32'(pending), 32'h7);
        wr(8'h1C, 32'h0); chk("R3 ext clear", 32'(pending), 32'h6);
        wr(8'h44, 32'h0); chk("R3 tmr clear", 32'(pending), 32'h4);
        rd(8'h0C, rv);    chk("R3 rx clear", 32'(pending), 32'h0);

        // R4 partial mask write
        for (int s = 0; s < 3; s++) pulse_src(s);
        wr(8'h28, 32'h5);
        chk("R4 partial", 32'(pending), 32'h5);
        wr(8'h28, 32'h0); wr(8'h28, 32'h7);

        // R5 global enable gating
        pulse_src(1);
        boundary(32'h100, tk); chk("R5 gie off", 32'(tk), 32'h0);
        op(0); op(1);
        boundary(32'h104, tk); chk("R5 cli blocks", 32'(tk), 32'h0);
        // R7 iret from disabled inverts to enabled
        op(2);
        boundary(32'h108, tk); chk("R7 iret invert", 32'(tk), 32'h1);
        chk("R5 take clears gie", 32'(take_irq), 32'h0);
        boundary(32'h10C, tk); chk("R5 no retake", 32'(tk), 32'h0);
        chk("R6 ret_pc", ret_pc, 32'h108);
        clear_src(1);
        op(2);
        rd(8'h24, rv); chk("R7 inum zero", rv, 32'h0);
        op(1);

        // R8 R9 R12 sweep over every pending combination
        for (int m = 1; m < 8; m++) begin
            int rem;
            rem = m;
            for (int s = 0; s < 3; s++) if (m[s]) pulse_src(s);
            chk("R2 combo", 32'(pending), 32'(m));
            op(0);
            while (rem != 0) begin
                int lo;
                logic [31:0] pc;
                lo = (rem[0]) ? 0 : (rem[1]) ? 1 : 2;
                pc = 32'h2000 + 32'(m * 16 + lo * 4);
                boundary(pc, tk); chk("R12 take", 32'(tk), 32'h1);
                rd(8'h24, rv); chk("R9 R8 inum", rv, 32'(lo + 1));
                rd(8'h48, rv); chk("R6 prev", rv, pc);
                clear_src(lo);
                rem = rem & ~(1 << lo);
                chk("R3 cleared", 32'(pending), 32'(rem));
                op(2);
            end
            boundary(32'h3000, tk); chk("R12 idle", 32'(tk), 32'h0);
            rd(8'h24, rv); chk("R7 inum after", rv, 32'h0);
            op(1);
        end

        // R11 held pin gives one request
        ext_pin = 1'b1; repeat (4) tick();
        chk("R11 first", 32'(pending), 32'h1);
        clear_src(0); repeat (6) tick();
        chk("R11 held", 32'(pending), 32'h0);
        ext_pin = 1'b0; repeat (4) tick();
        chk("R11 fall", 32'(pending), 32'h0);
        ext_pin = 1'b1; repeat (4) tick();
        chk("R11 rerise", 32'(pending), 32'h1);
        ext_pin = 1'b0; clear_src(0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule